// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer arithmetic unit of a simple processor datapath. It takes two operands and an operation code and produces a result combinationally. A result-write strobe tells the register file when that result should be stored. Beside the datapath it keeps a four-bit status register holding negative, zero, overflow and carry flags. A later conditional branch tests these flags to decide signed and unsigned comparisons.

Addition, subtraction, compare and negate all run on a single adder. Arithmetic wraps modulo 2^WIDTH, so the same hardware serves signed and unsigned operands. Subtraction adds the inverted second operand and a carry-in of one. The carry out of the top bit is therefore a "no borrow" indication.

The logical right shift reports the last bit that left the word in the carry flag. A shadow copy of the flags can be taken and reloaded by two strobes, so that interrupt entry and return preserve the condition state. The flags register updates on the clock edge that ends the operation. The result itself is not registered.

Top module: `flag_alu`

## Requirements
- R1: Operation code 1 (add) outputs result = a + b mod 2^WIDTH with res_we high. With set_flags high, the next flags have C equal to the carry out of the top bit. V is 1 when a and b share a sign and the result's sign differs from it.
- R2: Operation code 2 (subtract) outputs result = a - b mod 2^WIDTH with res_we high. With set_flags high, the next flags have C = 1 exactly when a >= b as unsigned values. V is 1 exactly when the true signed difference is outside the signed range.
- R3: On every flags update from an operation, Z becomes 1 exactly when the result is all zeros, and N becomes the result's top bit. Flag bit positions are flags[3]=N, flags[2]=Z, flags[1]=V, flags[0]=C.
- R4: Operation code 3 (compare) holds res_we low. It updates all four flags exactly as subtract would, whatever the value of set_flags.
- R5: With set_flags low, add, subtract, negate and shift still write their result, but the flags keep their value.
- R6: Operation code 4 (negate) outputs ~a + 1, so that 0 maps to 0 and the most negative value maps to itself. With set_flags high, C = 1 only for a = 0, and V = 1 only for a equal to the most negative value.
- R7: Operation code 5 (logical shift right) shifts a right by the amount in b, with res_we high. Amounts of WIDTH or more give a zero result. With set_flags high, C becomes a[b-1] for amounts 1 to WIDTH and 0 for larger amounts. An amount of 0 leaves C unchanged, and V is never changed by a shift.
- R8: Operation code 0 and the unused codes 6 and 7 hold res_we low and leave the flags unchanged.
- R9: Reset (rst_n low) clears the flags and the shadow copy to 0000.
- R10: A save strobe copies the current flags (the value before any update in that cycle) into the shadow copy. A restore strobe reloads the flags from the shadow copy, and it wins over an operation's flag update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, or shift amount |
| op_sel | input | 3 | Operation code |
| set_flags | input | 1 | Allow the operation to update the flags |
| save_flags | input | 1 | Copy flags into the shadow copy |
| restore_flags | input | 1 | Reload flags from the shadow copy |
| result | output | WIDTH | Operation result |
| res_we | output | 1 | Result should be written |
| flags | output | 4 | Current N, Z, V, C |

## Verification
The assertions check several rules on every cycle:
- compare never raises the write strobe;
- the carry after a flag-setting subtract equals the unsigned a >= b comparison;
- the zero flag tracks the result that updated it;
- a shift never changes V;
- a restore always loads the shadow copy;
- a cycle with no update and no restore holds the flags.

Only the bench's sweeps can show the exact numeric results and the signed overflow rule over many operand pairs. The same holds for the negate corner values and the full shift-amount carry table, including amounts of exactly WIDTH and beyond. The bench is also needed for the save-before-update ordering and for restore winning over an update in the same cycle.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ADD = 3'd1,
        OP_SUB = 3'd2,
        OP_CMP = 3'd3,
        OP_NEG = 3'd4,
        OP_LSR = 3'd5
    } alu_op_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;
    logic [WIDTH:0] wide;

    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum  = wide[MSB:0];
        cout = wide[WIDTH];
        // overflow: both adder inputs agree in sign, sum disagrees
        ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] val,
    input  logic [WIDTH-1:0] amt,
    output logic [WIDTH-1:0] shifted,
    output logic             c_out,
    output logic             c_valid
);
    localparam int SW = $clog2(WIDTH);
    localparam logic [WIDTH-1:0] LIM = WIDTH[WIDTH-1:0];

    logic [SW-1:0] amt_lo;
    logic [SW-1:0] last_idx;

    always_comb begin
        amt_lo   = amt[SW-1:0];
        last_idx = amt_lo - SW'(1);
        shifted  = '0;
        c_out    = 1'b0;
        c_valid  = 1'b1;
        if (amt == '0) begin
            shifted = val;
            c_valid = 1'b0;
        end else if (amt == LIM) begin
            c_out = val[WIDTH-1];
        end else if (amt < LIM) begin
            shifted = val >> amt_lo;
            c_out   = val[last_idx];
        end
    end
endmodule

// File: rtl/alu_status.sv
module alu_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic [3:0] nxt,
    input  logic       save,
    input  logic       restore,
    output logic [3:0] flags
);
    logic [3:0] shadow;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags  <= 4'b0000;
            shadow <= 4'b0000;
        end else begin
            if (save)
                shadow <= flags;
            if (restore)
                flags <= shadow;
            else if (upd)
                flags <= nxt;
        end
    end

    // R10
    restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> flags == $past(shadow));

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !upd) |=> $stable(flags));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [2:0]       op_sel,
    input  logic             set_flags,
    input  logic             save_flags,
    input  logic             restore_flags,
    output logic [WIDTH-1:0] result,
    output logic             res_we,
    output logic [3:0]       flags
);
    localparam int MSB = WIDTH - 1;

    alu_op_e op;
    logic [WIDTH-1:0] add_x, add_y, add_s, sh_res;
    logic add_cin, add_cout, add_ovf, sh_c, sh_cv;
    logic upd;
    logic [3:0] nxt;

    assign op = alu_op_e'(op_sel);

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .x(add_x), .y(add_y), .cin(add_cin),
        .sum(add_s), .cout(add_cout), .ovf(add_ovf)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shr (
        .val(op_a), .amt(op_b),
        .shifted(sh_res), .c_out(sh_c), .c_valid(sh_cv)
    );

    alu_status u_stat (
        .clk(clk), .rst_n(rst_n), .upd(upd), .nxt(nxt),
        .save(save_flags), .restore(restore_flags), .flags(flags)
    );

    always_comb begin
        add_x   = op_a;
        add_y   = op_b;
        add_cin = 1'b0;
        result  = '0;
        res_we  = 1'b0;
        upd     = 1'b0;
        nxt     = flags;
        unique case (op)
            OP_ADD: begin
                result = add_s;
                res_we = 1'b1;
                upd    = set_flags;
            end
            OP_SUB: begin
                add_y   = ~op_b;
                add_cin = 1'b1;
                result  = add_s;
                res_we  = 1'b1;
                upd     = set_flags;
            end
            OP_CMP: begin
                add_y   = ~op_b;
                add_cin = 1'b1;
                result  = add_s;
                upd     = 1'b1;
            end
            OP_NEG: begin
                add_x   = '0;
                add_y   = ~op_a;
                add_cin = 1'b1;
                result  = add_s;
                res_we  = 1'b1;
                upd     = set_flags;
            end
            OP_LSR: begin
                result = sh_res;
                res_we = 1'b1;
                upd    = set_flags;
            end
            default: begin
                result = '0;
            end
        endcase
        nxt[FLG_N] = result[MSB];
        nxt[FLG_Z] = (result == '0);
        if (op == OP_LSR) begin
            nxt[FLG_C] = sh_cv ? sh_c : flags[FLG_C];
        end else begin
            nxt[FLG_V] = add_ovf;
            nxt[FLG_C] = add_cout;
        end
    end

    // R4
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd3) |-> !res_we);

    // R2
    sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2 && set_flags && !restore_flags)
        |=> flags[FLG_C] == ($past(op_a) >= $past(op_b)));

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !restore_flags) |=> flags[FLG_Z] == ($past(result) == '0));

    // R7
    shift_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd5 && !restore_flags) |=> flags[FLG_V] == $past(flags[FLG_V]));
endmodule

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;
    localparam int W = 8;
    localparam int M = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [2:0] op_sel = 3'd0;
    logic set_flags = 1'b0, save_flags = 1'b0, restore_flags = 1'b0;
    logic [W-1:0] result;
    logic res_we;
    logic [3:0] flags;

    int total = 0;
    int bad = 0;
    logic [3:0] mflags = 4'b0000;
    logic [3:0] mshadow = 4'b0000;
    bit finished = 0;

    always #2 clk = ~clk;

    flag_alu #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .set_flags(set_flags), .save_flags(save_flags), .restore_flags(restore_flags),
        .result(result), .res_we(res_we), .flags(flags)
    );

    function automatic int sgn(input int v);
        return (v > M / 2) ? v - (M + 1) : v;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input int op, input int a, input int b,
                          input bit sf, input bit sv, input bit rs);
        int res, tru;
        bit we, upd;
        logic [3:0] nf;
        @(negedge clk);
        op_sel = op[2:0]; op_a = a[W-1:0]; op_b = b[W-1:0];
        set_flags = sf; save_flags = sv; restore_flags = rs;
        res = 0; we = 0; upd = 0; nf = mflags;
        case (op)
            1: begin
                res = (a + b) & M; we = 1; upd = sf;
                nf[0] = (a + b) > M;
                tru = sgn(a) + sgn(b); nf[1] = (tru > M / 2) || (tru < -(M / 2) - 1);
            end
            2, 3: begin
                res = (a - b) & M; we = (op == 2); upd = (op == 3) || sf;
                nf[0] = a >= b;
                tru = sgn(a) - sgn(b); nf[1] = (tru > M / 2) || (tru < -(M / 2) - 1);
            end
            4: begin
                res = (0 - a) & M; we = 1; upd = sf;
                nf[0] = (a == 0); nf[1] = (a == (M + 1) / 2);
            end
            5: begin
                we = 1; upd = sf;
                res = (b >= W) ? 0 : (a >> b);
                if (b >= 1 && b <= W) nf[0] = (a >> (b - 1)) & 1;
                else if (b > W) nf[0] = 1'b0;
            end
            default: ;
        endcase
        nf[3] = (res >> (W - 1)) & 1;
        nf[2] = (res == 0);
        #1;
        check({tag, " res_we"}, int'(res_we), int'(we));
        if (we) check({tag, " result"}, int'(result), res);
        if (sv) mshadow = mflags;
        if (rs) mflags = (sv ? mflags : mshadow);
        if (rs && sv) mflags = mflags;
        if (!rs && upd) mflags = nf;
        @(posedge clk);
        #1;
        check({tag, " flags (R3 N/Z)"}, int'(flags), int'(mflags));
        save_flags = 0; restore_flags = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset flags", int'(flags), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a <= M; a++)
            for (int b = 0; b <= M; b += 17)
                run_op("R1 add", 1, a, b, 1, 0, 0);
        for (int a = 0; a <= M; a++)
            for (int b = 0; b <= M; b += 15)
                run_op("R2 sub", 2, a, b, 1, 0, 0);
        for (int a = 0; a <= M; a++)
            for (int b = 1; b <= M; b += 19)
                run_op("R4 cmp", 3, a, b, a[0], 0, 0);
        run_op("R4 cmp equal", 3, 77, 77, 0, 0, 0);
        run_op("R1 set", 1, 127, 1, 1, 0, 0);
        for (int a = 0; a <= M; a += 3) begin
            run_op("R5 add nosf", 1, a, 200, 0, 0, 0);
            run_op("R5 sub nosf", 2, a, 5, 0, 0, 0);
            run_op("R5 neg nosf", 4, a, 0, 0, 0, 0);
            run_op("R5 lsr nosf", 5, a, 3, 0, 0, 0);
        end
        for (int a = 0; a <= M; a++)
            run_op("R6 neg", 4, a, 0, 1, 0, 0);
        for (int a = 0; a <= M; a += 7)
            for (int s = 0; s <= W + 3; s++) begin
                if (s == 0) run_op("R7 prep", 1, 255, 1, 1, 0, 0);
                run_op("R7 lsr", 5, a, s, 1, 0, 0);
            end
        run_op("R7 prep", 1, 128, 128, 1, 0, 0);
        run_op("R7 lsr big", 5, 255, 200, 1, 0, 0);
        run_op("R7 lsr zero", 5, 129, 0, 1, 0, 0);
        for (int c = 0; c < 8; c++)
            if (c == 0 || c >= 6) run_op("R8 idle", c, 99, 45, 1, 0, 0);
        run_op("R10 make", 1, 127, 1, 1, 0, 0);
        run_op("R10 save", 0, 0, 0, 0, 1, 0);
        run_op("R10 change", 1, 0, 0, 1, 0, 0);
        run_op("R10 restore wins", 1, 255, 1, 1, 0, 1);
        run_op("R10 save before update", 1, 0, 0, 1, 1, 0);
        run_op("R10 change2", 2, 1, 2, 1, 0, 0);
        run_op("R10 restore", 0, 0, 0, 0, 0, 1);
        finish_run();
    end
endmodule